// File: doc/BRIEF.md
# Serial Register Access Slave

This block is a four-wire serial slave that gives a host read and write access to a small bank of 8-bit control registers. The host lowers an active-low select, toggles a serial clock and shifts in a 16-bit frame. The frame holds a direction flag, a 7-bit register address and an 8-bit data byte, all sent most significant bit first. The block holds the register file and presents its full contents as a flat vector to the logic that uses the settings. It pulses a write strobe when a register takes a new value and a read request when a read address has been received. When a read frame completes, it pulses an event-clear line to the interrupt logic.

Read data leaves on one of three shared output pins, chosen by a 2-bit selector, or on no pin at all. A separate control input sets what a selected pin does while no read data is being sent: it either drives low or is released to high impedance. The block runs from a control-domain clock and brings the serial lines in through synchronisers, so it needs no audio master clock.

The frame engine is a state machine with five states. S_IDLE is the rest state while select is high. A falling edge on select moves it to S_CMD, which collects the direction bit and the address. On the eighth sampled bit it goes to S_WDATA if the direction bit is 1, or to S_RDATA if it is 0. On the sixteenth sampled bit it goes from either data state to S_DONE. In S_DONE further clock edges are ignored. From any state, select going high returns the machine to S_IDLE; before S_DONE this cancels the access.

Top module: `serial_reg_slave`

## Requirements
- R1: After reset every register reads 0x00, no strobe or event-clear is active, and with the selector at 00 no output pin is enabled.
- R2: A frame that begins with bit 1 is a write. The 7 address bits and then the 8 data bits are sampled on rising serial-clock edges, MSB first. When the sixteenth bit is sampled, the addressed register takes the data byte and `wr_stb_o` pulses for one clock.
- R3: A frame that begins with bit 0 is a read. The addressed register is shifted out MSB first on the selected pin. Each bit changes after a falling serial-clock edge, and the first bit appears after the falling edge that follows the last address bit.
- R4: During the data phase of a read, the serial data input is ignored and no register changes.
- R5: Selector value 00 enables no pin, 01 enables pin 0, 10 enables pin 1 and 11 enables pin 2. No other pin is ever enabled.
- R6: While no read data is being sent, the selected pin drives 0 if `idle_hiz_i` is 0 and is disabled if `idle_hiz_i` is 1. During the read data phase it is always driven.
- R7: `evt_clr_o` pulses for one clock when a read frame receives its sixteenth bit, whatever the selector value. A write frame never raises it.
- R8: If select rises before the sixteenth bit, the access is cancelled: no register is written and no event-clear is issued.
- R9: Addresses above 36 read as 0x00. A write to such an address changes nothing and raises no `wr_stb_o`.
- R10: Serial-clock edges after the sixteenth bit and before select rises have no effect.
- R11: `rd_stb_o` pulses once per read frame, when the last address bit is sampled, with the address on `acc_addr_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control-domain clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csn_i | input | 1 | Serial select, active low |
| sclk_i | input | 1 | Serial clock |
| sdi_i | input | 1 | Serial data in |
| out_sel_i | input | 2 | Output pin selector (00 none, 01/10/11 pin 0/1/2) |
| idle_hiz_i | input | 1 | Release the selected pin while idle |
| pad_out_o | output | 3 | Data value for each shared pin |
| pad_oe_o | output | 3 | Drive enable for each shared pin |
| regs_o | output | 296 | Register contents, register n at bits [8n+7:8n] |
| wr_stb_o | output | 1 | One-clock pulse on a register update |
| rd_stb_o | output | 1 | One-clock pulse when a read address is received |
| acc_addr_o | output | 7 | Address of the current access |
| wr_data_o | output | 8 | Byte of the last write |
| evt_clr_o | output | 1 | One-clock event-clear pulse on read completion |

## Verification
Checks inside the RTL run on every cycle. They cover the following:
- at most one pin is ever enabled;
- a deselect always returns the engine to idle;
- write strobes and event-clears come only from the matching data state finishing;
- the read-data bit changes only on a falling serial-clock edge or at frame start;
- no register moves without an accepted write.

Some behaviours can only be shown by the bench scenarios. These are the actual byte values that come back, the MSB-first order, the mapping of selector codes to pins and the zero returned above address 36. They also include cancelled frames, trailing clock edges being ignored, and the event-clear on a read with no pin selected.

// File: rtl/srs_pkg.sv
package srs_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_CMD,
        S_WDATA,
        S_RDATA,
        S_DONE
    } srs_state_e;
endpackage

// File: rtl/srs_edge_sync.sv
module srs_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic csn_i,
    input  logic sclk_i,
    input  logic sdi_i,
    output logic csn_s,
    output logic sdi_s,
    output logic cs_fall,
    output logic sclk_rise,
    output logic sclk_fall
);
    logic [STAGES-1:0] csn_sh, sclk_sh, sdi_sh;
    logic              csn_d, sclk_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            csn_sh  <= '1;
            sclk_sh <= '0;
            sdi_sh  <= '0;
            csn_d   <= 1'b1;
            sclk_d  <= 1'b0;
        end else begin
            csn_sh  <= {csn_sh[STAGES-2:0], csn_i};
            sclk_sh <= {sclk_sh[STAGES-2:0], sclk_i};
            sdi_sh  <= {sdi_sh[STAGES-2:0], sdi_i};
            csn_d   <= csn_sh[STAGES-1];
            sclk_d  <= sclk_sh[STAGES-1];
        end
    end

    assign csn_s     = csn_sh[STAGES-1];
    assign sdi_s     = sdi_sh[STAGES-1];
    assign cs_fall   = csn_d & ~csn_s;
    assign sclk_rise = ~sclk_d & sclk_sh[STAGES-1];
    assign sclk_fall = sclk_d & ~sclk_sh[STAGES-1];
endmodule

// File: rtl/srs_frame_fsm.sv
module srs_frame_fsm
    import srs_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csn_s,
    input  logic              cs_fall,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    input  logic              sdi_s,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] wdata_o,
    output logic              wr_req_o,
    output logic              rd_req_o,
    output logic              evt_clr_o,
    output logic              sdo_o,
    output logic              rd_phase_o
);
    localparam int CMD_BITS   = 1 + ADDR_W;
    localparam int FRAME_BITS = CMD_BITS + DATA_W;
    localparam int CNT_W      = $clog2(FRAME_BITS + 1);
    localparam logic [CNT_W-1:0] LAST_CMD   = CNT_W'(CMD_BITS - 1);
    localparam logic [CNT_W-1:0] LAST_FRAME = CNT_W'(FRAME_BITS - 1);

    srs_state_e        st_q, st_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [ADDR_W-1:0] sh_q;
    logic [CMD_BITS-1:0] nxt_sh;
    logic [DATA_W-1:0] rdsh_q;
    logic              load_q;
    logic              cmd_end, frame_end;

    assign nxt_sh    = {sh_q, sdi_s};
    assign cmd_end   = sclk_rise && (cnt_q == LAST_CMD);
    assign frame_end = sclk_rise && (cnt_q == LAST_FRAME);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= S_IDLE;
        else        st_q <= st_d;
    end

    // next-state logic
    always_comb begin
        st_d = st_q;
        if (csn_s) begin
            st_d = S_IDLE;
        end else begin
            unique case (st_q)
                S_IDLE:  if (cs_fall) st_d = S_CMD;
                S_CMD:   if (cmd_end) st_d = nxt_sh[ADDR_W] ? S_WDATA : S_RDATA;
                S_WDATA: if (frame_end) st_d = S_DONE;
                S_RDATA: if (frame_end) st_d = S_DONE;
                S_DONE:  st_d = S_DONE;
                default: st_d = S_IDLE;
            endcase
        end
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            sh_q      <= '0;
            rdsh_q    <= '0;
            load_q    <= 1'b0;
            addr_o    <= '0;
            wdata_o   <= '0;
            wr_req_o  <= 1'b0;
            rd_req_o  <= 1'b0;
            evt_clr_o <= 1'b0;
            sdo_o     <= 1'b0;
        end else begin
            wr_req_o  <= 1'b0;
            rd_req_o  <= 1'b0;
            evt_clr_o <= 1'b0;
            load_q    <= rd_req_o;
            if (load_q) rdsh_q <= rd_data;
            if (cs_fall) begin
                cnt_q <= '0;
                sh_q  <= '0;
                sdo_o <= 1'b0;
            end else if (!csn_s) begin
                if (sclk_rise && (st_q == S_CMD || st_q == S_WDATA)) begin
                    sh_q  <= nxt_sh[ADDR_W-1:0];
                    cnt_q <= cnt_q + 1'b1;
                end
                if (sclk_rise && st_q == S_RDATA) cnt_q <= cnt_q + 1'b1;
                if (st_q == S_CMD && cmd_end) begin
                    addr_o   <= nxt_sh[ADDR_W-1:0];
                    rd_req_o <= ~nxt_sh[ADDR_W];
                end
                if (st_q == S_WDATA && frame_end) begin
                    wr_req_o <= 1'b1;
                    wdata_o  <= nxt_sh[DATA_W-1:0];
                end
                if (st_q == S_RDATA && frame_end) evt_clr_o <= 1'b1;
                if (st_q == S_RDATA && sclk_fall) begin
                    sdo_o  <= rdsh_q[DATA_W-1];
                    rdsh_q <= {rdsh_q[DATA_W-2:0], 1'b0};
                end
            end
        end
    end

    assign rd_phase_o = (st_q == S_RDATA);

    a_r8_deselect_idles: assert property (@(posedge clk) disable iff (!rst_n)
        csn_s |=> st_q == S_IDLE);
    a_r7_clear_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        evt_clr_o |-> (st_q == S_DONE && $past(st_q) == S_RDATA));
    a_r2_write_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req_o |-> (st_q == S_DONE && $past(st_q) == S_WDATA));
    a_r3_launch_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (!sclk_fall && !cs_fall) |=> $stable(sdo_o));
    a_r11_single_read_req: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o |=> !rd_req_o);
endmodule

// File: rtl/srs_regfile.sv
module srs_regfile #(
    parameter int ADDR_W   = 7,
    parameter int DATA_W   = 8,
    parameter int LAST_REG = 36
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [ADDR_W-1:0]            addr,
    input  logic [DATA_W-1:0]            wdata,
    input  logic                         wr_req,
    output logic                         wr_acc,
    output logic [DATA_W-1:0]            rd_data,
    output logic [(LAST_REG+1)*DATA_W-1:0] regs_flat
);
    localparam int NREG = LAST_REG + 1;

    assign wr_acc = wr_req && (addr <= ADDR_W'(LAST_REG));

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                regs_flat[i*DATA_W +: DATA_W] <= '0;
            else if (wr_acc && addr == ADDR_W'(i))
                regs_flat[i*DATA_W +: DATA_W] <= wdata;
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NREG; i++) begin
            if (addr == ADDR_W'(i)) rd_data = regs_flat[i*DATA_W +: DATA_W];
        end
    end

    a_r9_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_acc |=> $stable(regs_flat));
endmodule

// File: rtl/srs_pin_mux.sv
module srs_pin_mux #(
    parameter int N_PINS = 3,
    parameter int SEL_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEL_W-1:0]  sel,
    input  logic              idle_hiz,
    input  logic              rd_phase,
    input  logic              sdo,
    output logic [N_PINS-1:0] pad_out,
    output logic [N_PINS-1:0] pad_oe
);
    for (genvar k = 0; k < N_PINS; k++) begin : g_pin
        logic hit;
        assign hit        = (sel == SEL_W'(k + 1));
        assign pad_out[k] = hit & rd_phase & sdo;
        assign pad_oe[k]  = hit & (rd_phase | ~idle_hiz);
    end

    a_r5_single_pin: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pad_oe));
    a_r6_driven_in_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_phase && sel != '0) |-> $countones(pad_oe) == 1);
endmodule

// File: rtl/serial_reg_slave.sv
module serial_reg_slave #(
    parameter int ADDR_W      = 7,
    parameter int DATA_W      = 8,
    parameter int LAST_REG    = 36,
    parameter int N_PINS      = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             csn_i,
    input  logic                             sclk_i,
    input  logic                             sdi_i,
    input  logic [1:0]                       out_sel_i,
    input  logic                             idle_hiz_i,
    output logic [N_PINS-1:0]                pad_out_o,
    output logic [N_PINS-1:0]                pad_oe_o,
    output logic [(LAST_REG+1)*DATA_W-1:0]   regs_o,
    output logic                             wr_stb_o,
    output logic                             rd_stb_o,
    output logic [ADDR_W-1:0]                acc_addr_o,
    output logic [DATA_W-1:0]                wr_data_o,
    output logic                             evt_clr_o
);
    logic csn_s, sdi_s, cs_fall, sclk_rise, sclk_fall;
    logic wr_req, sdo, rd_phase;
    logic [DATA_W-1:0] rd_data;

    srs_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .csn_i(csn_i), .sclk_i(sclk_i), .sdi_i(sdi_i),
        .csn_s(csn_s), .sdi_s(sdi_s), .cs_fall(cs_fall),
        .sclk_rise(sclk_rise), .sclk_fall(sclk_fall)
    );

    srs_frame_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .csn_s(csn_s), .cs_fall(cs_fall),
        .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .sdi_s(sdi_s),
        .rd_data(rd_data), .addr_o(acc_addr_o), .wdata_o(wr_data_o),
        .wr_req_o(wr_req), .rd_req_o(rd_stb_o), .evt_clr_o(evt_clr_o),
        .sdo_o(sdo), .rd_phase_o(rd_phase)
    );

    srs_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LAST_REG(LAST_REG)) u_regs (
        .clk(clk), .rst_n(rst_n), .addr(acc_addr_o), .wdata(wr_data_o),
        .wr_req(wr_req), .wr_acc(wr_stb_o), .rd_data(rd_data), .regs_flat(regs_o)
    );

    srs_pin_mux #(.N_PINS(N_PINS), .SEL_W(2)) u_mux (
        .clk(clk), .rst_n(rst_n), .sel(out_sel_i), .idle_hiz(idle_hiz_i),
        .rd_phase(rd_phase), .sdo(sdo), .pad_out(pad_out_o), .pad_oe(pad_oe_o)
    );
endmodule

// File: tb/sim_serial_reg_slave.sv
module sim_serial_reg_slave;
    logic clk = 1'b0, rst_n = 1'b0;
    logic csn = 1'b1, sclk = 1'b0, sdi = 1'b0;
    logic [1:0] sel = 2'b00;
    logic hiz = 1'b0;
    logic [2:0] pad_out, pad_oe;
    logic [295:0] regs;
    logic wr_stb, rd_stb, evt_clr;
    logic [6:0] acc_addr;
    logic [7:0] wr_data;

    int checks = 0, fails = 0;
    int wr_cnt = 0, rd_cnt = 0, evt_cnt = 0;
    logic [7:0] rb;
    bit stray;
    bit done = 0;

    always #4 clk = ~clk;

    serial_reg_slave u0 (
        .clk(clk), .rst_n(rst_n), .csn_i(csn), .sclk_i(sclk), .sdi_i(sdi),
        .out_sel_i(sel), .idle_hiz_i(hiz), .pad_out_o(pad_out), .pad_oe_o(pad_oe),
        .regs_o(regs), .wr_stb_o(wr_stb), .rd_stb_o(rd_stb), .acc_addr_o(acc_addr),
        .wr_data_o(wr_data), .evt_clr_o(evt_clr)
    );

    always @(posedge clk) begin
        if (wr_stb) wr_cnt++;
        if (rd_stb) rd_cnt++;
        if (evt_clr) evt_cnt++;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // frame bits taken MSB first from fr[23]
    task automatic xfer(input logic [23:0] fr, input int nbits);
        logic [2:0] mask;
        mask = (sel == 2'b00) ? 3'b000 : 3'(1 << (sel - 1));
        rb = '0;
        stray = 0;
        csn = 1'b0;
        repeat (8) @(posedge clk);
        for (int i = 0; i < nbits; i++) begin
            sdi = fr[23-i];
            repeat (4) @(negedge clk);
            if (i >= 8 && i < 16) begin
                if (sel != 2'b00) rb[15-i] = pad_out[sel-1];
                if ((pad_oe & ~mask) != 3'b000) stray = 1;
                if (sel != 2'b00 && pad_oe[sel-1] !== 1'b1) stray = 1;
            end
            sclk = 1'b1;
            repeat (8) @(posedge clk);
            sclk = 1'b0;
            repeat (4) @(posedge clk);
        end
        repeat (8) @(posedge clk);
        csn = 1'b1;
        repeat (10) @(posedge clk);
    endtask

    // {is_write, addr, data driven, expected read value}
    localparam logic [23:0] VEC [0:10] = '{
        {1'b1, 7'd0,   8'hA5, 8'h00},
        {1'b1, 7'd5,   8'h3C, 8'h00},
        {1'b1, 7'd36,  8'h81, 8'h00},
        {1'b1, 7'd37,  8'hFF, 8'h00},
        {1'b0, 7'd0,   8'hFF, 8'hA5},
        {1'b0, 7'd5,   8'h00, 8'h3C},
        {1'b0, 7'd36,  8'h5A, 8'h81},
        {1'b0, 7'd37,  8'hFF, 8'h00},
        {1'b0, 7'd100, 8'h00, 8'h00},
        {1'b1, 7'd5,   8'hC3, 8'h00},
        {1'b0, 7'd5,   8'h00, 8'hC3}
    };

    initial begin
        repeat (5) @(posedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        // R1 reset state
        chk("R1 regs", {31'b0, regs == '0}, 32'd1);
        chk("R1 oe", {29'b0, pad_oe}, 32'd0);
        chk("R1 strobes", {29'b0, wr_stb, rd_stb, evt_clr}, 32'd0);

        sel = 2'b10;
        for (int v = 0; v < 11; v++) begin
            logic [23:0] e;
            int w0, r0, c0;
            e = VEC[v];
            w0 = wr_cnt; r0 = rd_cnt; c0 = evt_cnt;
            xfer({e[23:8], 8'h00}, 16);
            if (e[23]) begin
                chk("R2/R9 write strobe", wr_cnt - w0, (e[22:16] <= 36) ? 1 : 0);
                if (e[22:16] <= 36)
                    chk("R2 stored", {24'b0, regs[e[22:16]*8 +: 8]}, {24'b0, e[15:8]});
                chk("R7 no clear on write", evt_cnt - c0, 0);
            end else begin
                chk("R3/R9 read value", {24'b0, rb}, {24'b0, e[7:0]});
                chk("R7 clear on read", evt_cnt - c0, 1);
                chk("R11 read request", rd_cnt - r0, 1);
                chk("R11 address", {25'b0, acc_addr}, {25'b0, e[22:16]});
                chk("R5 pin ownership", {31'b0, stray}, 0);
            end
        end
        chk("R9 reg36 kept", {24'b0, regs[36*8 +: 8]}, 32'h81);

        // R4 sdi ignored during read data
        xfer({1'b0, 7'd0, 8'hFF, 8'h00}, 16);
        chk("R4 reg unchanged", {24'b0, regs[7:0]}, 32'hA5);
        chk("R4 read value", {24'b0, rb}, 32'hA5);

        // R5 other selector codes
        sel = 2'b01;
        xfer({1'b0, 7'd5, 8'h00, 8'h00}, 16);
        chk("R5 pin0 value", {24'b0, rb}, 32'hC3);
        chk("R5 pin0 only", {31'b0, stray}, 0);
        sel = 2'b11;
        xfer({1'b0, 7'd36, 8'h00, 8'h00}, 16);
        chk("R5 pin2 value", {24'b0, rb}, 32'h81);
        chk("R5 pin2 only", {31'b0, stray}, 0);

        // R6 idle behaviour
        sel = 2'b10; hiz = 1'b0;
        repeat (2) @(negedge clk);
        chk("R6 idle driven", {28'b0, pad_oe, pad_out[1]}, 32'b0100);
        hiz = 1'b1;
        repeat (2) @(negedge clk);
        chk("R6 idle released", {29'b0, pad_oe}, 0);
        xfer({1'b0, 7'd0, 8'h00, 8'h00}, 16);
        chk("R6 driven in read", {24'b0, rb}, 32'hA5);
        chk("R6 oe in read", {31'b0, stray}, 0);
        hiz = 1'b0;

        // R7 read with no pin selected
        begin
            int c0;
            sel = 2'b00;
            c0 = evt_cnt;
            xfer({1'b0, 7'd1, 8'h00, 8'h00}, 16);
            chk("R7 clear with no pin", evt_cnt - c0, 1);
            chk("R5 none enabled", {29'b0, pad_oe}, 0);
        end

        // R8 aborted write and read
        begin
            int w0, c0;
            w0 = wr_cnt; c0 = evt_cnt;
            xfer({1'b1, 7'd0, 8'h00, 8'h00}, 12);
            chk("R8 aborted write reg", {24'b0, regs[7:0]}, 32'hA5);
            chk("R8 aborted write strobe", wr_cnt - w0, 0);
            xfer({1'b0, 7'd0, 8'h00, 8'h00}, 12);
            chk("R8 aborted read clear", evt_cnt - c0, 0);
        end

        // R10 trailing clocks ignored
        begin
            int w0;
            w0 = wr_cnt;
            xfer({1'b1, 7'd2, 8'h69, 8'hFF}, 24);
            chk("R10 reg2", {24'b0, regs[2*8 +: 8]}, 32'h69);
            chk("R10 one strobe", wr_cnt - w0, 1);
            chk("R10 wr data", {24'b0, wr_data}, 32'h69);
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual running, expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule